// File: doc/BRIEF.md
# Serial-Probe Pseudo-Associative Cache

This block gives a direct-mapped storage array most of the conflict tolerance of an N-way set-associative cache without N parallel tag comparators. The array of K blocks is split into K/N logical sets. Each set owns N physical locations, and the block visits them one after another. For probe number p, the physical row is the probe number concatenated above the low set-index bits of the request address. A lookup ends at the first valid row whose stored tag matches, or it becomes a miss once all N rows have been checked.

On a miss the block asks the next level for the block over a fill port. It writes the returned data into the first row found empty during the probe sequence, or into probe row 0 when the set is full. It then answers the requester with a miss response that carries the filled data. Only one lookup is in flight at a time, and the requester sees this through a ready signal.

Top module: `pac_cache`

## Requirements
- R1: After reset, req_ready is 1, resp_valid and fill_req_valid are 0, and every row is invalid, so the first lookup of any address misses.
- R2: req_ready is 1 only while no lookup is in progress. A request is taken on a clock edge where req_valid and req_ready are both 1, and req_ready is 0 from the next cycle until the response cycle has passed.
- R3: Probe p reads physical row {p, addr[IDX_W-1:0]}, where IDX_W = log2(K/N). The stored tag is addr[ADDR_W-1:IDX_W]. A hit needs a valid row and an equal tag, so addresses that differ in their set bits never share rows.
- R4: When probe p is the first to hit, resp_valid is 1 for exactly one cycle. That cycle is the (p+1)-th after acceptance, with resp_hit=1, resp_slot=p and resp_data equal to the stored block.
- R5: Probes run in the order 0,1,...,N-1, and each further probe runs only after the one before it has missed. After N misses, fill_req_valid goes to 1 in cycle N+1 after acceptance, with fill_req_addr equal to the request address. Both hold until fill_rsp_valid is 1.
- R6: On a fill, the row used is the lowest probe number that was invalid in this lookup, or probe 0 if all rows were valid. The response follows in the cycle after fill_rsp_valid, with resp_hit=0, resp_slot equal to the row used and resp_data equal to the fill data.
- R7: A filled block is returned as a hit by later lookups of the same address until another fill replaces its row.
- R8: req_valid has no effect while req_ready is 0. Each accepted request produces exactly one response, and no response appears while the block is idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Lookup request present |
| req_addr | input | ADDR_W | Block address to look up |
| req_ready | output | 1 | Block idle; request will be taken |
| resp_valid | output | 1 | One-cycle response strobe |
| resp_hit | output | 1 | 1 = found in array, 0 = filled from next level |
| resp_slot | output | PROBE_W | Probe number that hit or was filled |
| resp_data | output | DATA_W | Block data |
| fill_req_valid | output | 1 | Next-level fetch request |
| fill_req_addr | output | ADDR_W | Address to fetch |
| fill_rsp_valid | input | 1 | Next-level data present |
| fill_rsp_data | input | DATA_W | Fetched block data |

## Verification
The assertions assume that the next level raises fill_rsp_valid only while fill_req_valid is 1, and that fill_rsp_data is valid in that same cycle. The bench keeps to this by answering a fetch only after it has seen fill_req_valid, and by dropping fill_rsp_valid right after one edge. During lookups the bench also drives a stray req_valid. It always removes that stray request before the block returns to idle, so the latency counter used by the assertions restarts only on real acceptances.

// File: rtl/pac_pkg.sv
// Shared types for the serial-probe cache.
// Assumes: nothing beyond IEEE 1800-2017.
package pac_pkg;
    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_PROBE = 2'd1,
        ST_FILL  = 2'd2,
        ST_RESP  = 2'd3
    } pac_state_e;
endpackage

// File: rtl/pac_store.sv
// Direct-mapped row storage: valid bit, tag and data per row.
// Reads are combinational, writes are synchronous. Only the valid
// bits are cleared by reset. Assumes one write port and one read port.
module pac_store #(
    parameter int ROWS   = 16,
    parameter int TAG_W  = 6,
    parameter int DATA_W = 16,
    localparam int ROW_W = $clog2(ROWS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ROW_W-1:0]  rd_row,
    output logic              rd_valid,
    output logic [TAG_W-1:0]  rd_tag,
    output logic [DATA_W-1:0] rd_data,
    input  logic              wr_en,
    input  logic [ROW_W-1:0]  wr_row,
    input  logic [TAG_W-1:0]  wr_tag,
    input  logic [DATA_W-1:0] wr_data
);
    logic [ROWS-1:0]   valid_q;
    logic [TAG_W-1:0]  tag_q  [ROWS];
    logic [DATA_W-1:0] data_q [ROWS];

    // Valid bits: clear on reset, set on write.
    always_ff @(posedge clk) begin
        if (!rst_n)     valid_q <= '0;
        else if (wr_en) valid_q[wr_row] <= 1'b1;
    end

    // Tag and data payload: written on fill.
    always_ff @(posedge clk) begin
        if (wr_en) begin
            tag_q[wr_row]  <= wr_tag;
            data_q[wr_row] <= wr_data;
        end
    end

    // Combinational read of the addressed row.
    always_comb begin
        rd_valid = valid_q[rd_row];
        rd_tag   = tag_q[rd_row];
        rd_data  = data_q[rd_row];
    end
endmodule

// File: rtl/pac_victim.sv
// Records the first invalid probe number seen during a lookup.
// Gives probe 0 if none was seen. Assumes clear is pulsed at
// acceptance and observe is high only in probe cycles.
module pac_victim #(
    parameter int PROBE_W = 2
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               clear,
    input  logic               observe,
    input  logic [PROBE_W-1:0] probe_num,
    input  logic               row_valid,
    output logic [PROBE_W-1:0] victim
);
    logic               found_q;
    logic [PROBE_W-1:0] slot_q;

    // Latch the first empty row of the current lookup.
    always_ff @(posedge clk) begin
        if (!rst_n || clear) begin
            found_q <= 1'b0;
            slot_q  <= '0;
        end else if (observe && !found_q && !row_valid) begin
            found_q <= 1'b1;
            slot_q  <= probe_num;
        end
    end

    // Default to probe 0 when the set is full.
    always_comb victim = found_q ? slot_q : '0;
endmodule

// File: rtl/pac_ctrl.sv
// Lookup sequencer: one probe per cycle in order 0..N-1, a fill
// request after N misses, then a response. Assumes N is a power
// of two >= 2 and that the next level answers only while asked.
module pac_ctrl
    import pac_pkg::*;
#(
    parameter int ADDR_W  = 8,
    parameter int IDX_W   = 2,
    parameter int PROBE_W = 2,
    parameter int WAYS    = 4,
    parameter int DATA_W  = 16,
    localparam int TAG_W  = ADDR_W - IDX_W,
    localparam int ROW_W  = PROBE_W + IDX_W
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               req_valid,
    input  logic [ADDR_W-1:0]  req_addr,
    output logic               req_ready,
    output logic               resp_valid,
    output logic               resp_hit,
    output logic [PROBE_W-1:0] resp_slot,
    output logic [DATA_W-1:0]  resp_data,
    output logic               fill_req_valid,
    output logic [ADDR_W-1:0]  fill_req_addr,
    input  logic               fill_rsp_valid,
    input  logic [DATA_W-1:0]  fill_rsp_data,
    output logic [ROW_W-1:0]   rd_row,
    input  logic               rd_valid,
    input  logic [TAG_W-1:0]   rd_tag,
    input  logic [DATA_W-1:0]  rd_data,
    output logic               wr_en,
    output logic [ROW_W-1:0]   wr_row,
    output logic [TAG_W-1:0]   wr_tag,
    output logic [DATA_W-1:0]  wr_data,
    output logic               accept,
    output logic               probing,
    output logic [PROBE_W-1:0] probe_num,
    input  logic [PROBE_W-1:0] victim
);
    localparam logic [PROBE_W-1:0] LAST_PROBE = PROBE_W'(WAYS - 1);

    pac_state_e         state_q;
    logic [ADDR_W-1:0]  addr_q;
    logic [PROBE_W-1:0] probe_q;
    logic [DATA_W-1:0]  fill_q;
    logic               hit;

    // Probe address, tag compare and handshake decode.
    always_comb begin
        accept    = (state_q == ST_IDLE) && req_valid;
        probing   = (state_q == ST_PROBE);
        probe_num = probe_q;
        rd_row    = {probe_q, addr_q[IDX_W-1:0]};
        hit       = probing && rd_valid && (rd_tag == addr_q[ADDR_W-1:IDX_W]);
        req_ready = (state_q == ST_IDLE);
    end

    // Response and fill-port outputs.
    always_comb begin
        resp_valid     = hit || (state_q == ST_RESP);
        resp_hit       = probing;
        resp_slot      = probing ? probe_q : victim;
        resp_data      = probing ? rd_data : fill_q;
        fill_req_valid = (state_q == ST_FILL);
        fill_req_addr  = addr_q;
        wr_en          = (state_q == ST_FILL) && fill_rsp_valid;
        wr_row         = {victim, addr_q[IDX_W-1:0]};
        wr_tag         = addr_q[ADDR_W-1:IDX_W];
        wr_data        = fill_rsp_data;
    end

    // Sequencer state, captured address, probe counter and fill data.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            addr_q  <= '0;
            probe_q <= '0;
            fill_q  <= '0;
        end else begin
            case (state_q)
                ST_IDLE: if (req_valid) begin
                    state_q <= ST_PROBE;
                    addr_q  <= req_addr;
                    probe_q <= '0;
                end
                ST_PROBE: begin
                    if (hit)                        state_q <= ST_IDLE;
                    else if (probe_q == LAST_PROBE) state_q <= ST_FILL;
                    else                            probe_q <= probe_q + 1'b1;
                end
                ST_FILL: if (fill_rsp_valid) begin
                    state_q <= ST_RESP;
                    fill_q  <= fill_rsp_data;
                end
                default: state_q <= ST_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/pac_cache.sv
// Top level of the serial-probe pseudo-associative cache. NUM_BLOCKS
// rows form NUM_BLOCKS/WAYS sets; probe p of a set uses row
// {p, set}. Assumes NUM_BLOCKS and WAYS are powers of two, WAYS >= 2.
module pac_cache #(
    parameter int ADDR_W     = 8,
    parameter int DATA_W     = 16,
    parameter int NUM_BLOCKS = 16,
    parameter int WAYS       = 4,
    localparam int SETS      = NUM_BLOCKS / WAYS,
    localparam int IDX_W     = $clog2(SETS),
    localparam int PROBE_W   = $clog2(WAYS),
    localparam int TAG_W     = ADDR_W - IDX_W,
    localparam int ROW_W     = PROBE_W + IDX_W
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               req_valid,
    input  logic [ADDR_W-1:0]  req_addr,
    output logic               req_ready,
    output logic               resp_valid,
    output logic               resp_hit,
    output logic [PROBE_W-1:0] resp_slot,
    output logic [DATA_W-1:0]  resp_data,
    output logic               fill_req_valid,
    output logic [ADDR_W-1:0]  fill_req_addr,
    input  logic               fill_rsp_valid,
    input  logic [DATA_W-1:0]  fill_rsp_data
);
    logic [ROW_W-1:0]   rd_row, wr_row;
    logic               rd_valid, wr_en, accept, probing;
    logic [TAG_W-1:0]   rd_tag, wr_tag;
    logic [DATA_W-1:0]  rd_data, wr_data;
    logic [PROBE_W-1:0] probe_num, victim;

    pac_ctrl #(
        .ADDR_W(ADDR_W), .IDX_W(IDX_W), .PROBE_W(PROBE_W),
        .WAYS(WAYS), .DATA_W(DATA_W)
    ) u_ctrl (
        .clk(clk), .rst_n(rst_n),
        .req_valid(req_valid), .req_addr(req_addr), .req_ready(req_ready),
        .resp_valid(resp_valid), .resp_hit(resp_hit),
        .resp_slot(resp_slot), .resp_data(resp_data),
        .fill_req_valid(fill_req_valid), .fill_req_addr(fill_req_addr),
        .fill_rsp_valid(fill_rsp_valid), .fill_rsp_data(fill_rsp_data),
        .rd_row(rd_row), .rd_valid(rd_valid), .rd_tag(rd_tag), .rd_data(rd_data),
        .wr_en(wr_en), .wr_row(wr_row), .wr_tag(wr_tag), .wr_data(wr_data),
        .accept(accept), .probing(probing), .probe_num(probe_num),
        .victim(victim)
    );

    pac_store #(
        .ROWS(NUM_BLOCKS), .TAG_W(TAG_W), .DATA_W(DATA_W)
    ) u_store (
        .clk(clk), .rst_n(rst_n),
        .rd_row(rd_row), .rd_valid(rd_valid), .rd_tag(rd_tag), .rd_data(rd_data),
        .wr_en(wr_en), .wr_row(wr_row), .wr_tag(wr_tag), .wr_data(wr_data)
    );

    pac_victim #(
        .PROBE_W(PROBE_W)
    ) u_victim (
        .clk(clk), .rst_n(rst_n),
        .clear(accept), .observe(probing), .probe_num(probe_num),
        .row_valid(rd_valid), .victim(victim)
    );
endmodule

// File: rtl/pac_cache_chk.sv
// Protocol and timing checker for pac_cache, attached with bind.
// Assumes fill_rsp_valid is raised only while fill_req_valid is 1.
module pac_cache_chk #(
    parameter int ADDR_W  = 8,
    parameter int DATA_W  = 16,
    parameter int PROBE_W = 2
) (
    input logic               clk,
    input logic               rst_n,
    input logic               req_valid,
    input logic               req_ready,
    input logic               resp_valid,
    input logic               resp_hit,
    input logic [PROBE_W-1:0] resp_slot,
    input logic [DATA_W-1:0]  resp_data,
    input logic               fill_req_valid,
    input logic [ADDR_W-1:0]  fill_req_addr,
    input logic               fill_rsp_valid,
    input logic [DATA_W-1:0]  fill_rsp_data
);
    localparam int CW = PROBE_W + 4;
    logic [CW-1:0] lat_q;

    // Cycles elapsed since the last accepted request.
    always_ff @(posedge clk) begin
        if (!rst_n)                      lat_q <= '0;
        else if (req_valid && req_ready) lat_q <= CW'(1);
        else if (!req_ready)             lat_q <= lat_q + 1'b1;
    end

    a_r2_busy_after_accept: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid && req_ready |=> !req_ready);
    a_r2_busy_in_resp: assert property (@(posedge clk) disable iff (!rst_n)
        resp_valid |-> !req_ready);
    a_r4_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        resp_valid |=> !resp_valid);
    a_r4_hit_latency: assert property (@(posedge clk) disable iff (!rst_n)
        resp_valid && resp_hit |-> lat_q == CW'(resp_slot) + CW'(1));
    a_r5_fill_hold: assert property (@(posedge clk) disable iff (!rst_n)
        fill_req_valid && !fill_rsp_valid |=> fill_req_valid && $stable(fill_req_addr));
    a_r5_no_overlap: assert property (@(posedge clk) disable iff (!rst_n)
        !(fill_req_valid && resp_valid));
    a_r6_fill_resp: assert property (@(posedge clk) disable iff (!rst_n)
        fill_req_valid && fill_rsp_valid |=>
            resp_valid && !resp_hit && resp_data == $past(fill_rsp_data));
endmodule

bind pac_cache pac_cache_chk #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .PROBE_W(PROBE_W)
) u_chk (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .resp_valid(resp_valid), .resp_hit(resp_hit), .resp_slot(resp_slot),
    .resp_data(resp_data), .fill_req_valid(fill_req_valid),
    .fill_req_addr(fill_req_addr), .fill_rsp_valid(fill_rsp_valid),
    .fill_rsp_data(fill_rsp_data)
);

// File: tb/pac_cache_tb.sv
// Bench for pac_cache: set-by-set sweeps against an arithmetic row model.
module pac_cache_tb;
    localparam int AW = 8, DW = 16, NB = 16, NW = 4, NS = NB / NW;

    logic          clk = 1'b0, rst_n = 1'b0;
    logic          req_valid = 1'b0, fill_rsp_valid = 1'b0;
    logic [AW-1:0] req_addr = '0;
    logic [DW-1:0] fill_rsp_data = '0;
    logic          req_ready, resp_valid, resp_hit, fill_req_valid;
    logic [1:0]    resp_slot;
    logic [DW-1:0] resp_data;
    logic [AW-1:0] fill_req_addr;

    int checks = 0, failures = 0;
    int fill_seq = 0;
    bit          m_v [NB];
    logic [5:0]  m_t [NB];
    logic [DW-1:0] m_d [NB];

    always #2.5 clk = ~clk;

    pac_cache u_dut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_addr(req_addr),
        .req_ready(req_ready), .resp_valid(resp_valid), .resp_hit(resp_hit),
        .resp_slot(resp_slot), .resp_data(resp_data),
        .fill_req_valid(fill_req_valid), .fill_req_addr(fill_req_addr),
        .fill_rsp_valid(fill_rsp_valid), .fill_rsp_data(fill_rsp_data)
    );

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    // One lookup; poke drives a stray request while busy (R8).
    task automatic access(input logic [AW-1:0] a, input bit poke);
        int s, n, eslot, elat;
        bit ehit, seen;
        logic [DW-1:0] edata;
        s = int'(a[1:0]);
        ehit = 1'b0; eslot = 0;
        for (int p = 0; p < NW; p++)
            if (!ehit && m_v[p*NS+s] && m_t[p*NS+s] == a[7:2]) begin
                ehit = 1'b1; eslot = p;
            end
        if (!ehit) begin
            seen = 1'b0;
            for (int p = 0; p < NW; p++)
                if (!seen && !m_v[p*NS+s]) begin seen = 1'b1; eslot = p; end
        end
        edata = m_d[eslot*NS+s];
        elat = ehit ? eslot + 1 : NW + 2;

        @(negedge clk);
        chk(req_ready == 1'b1, "R2", "ready before request", int'(req_ready), 1);
        req_valid = 1'b1; req_addr = a;
        @(negedge clk);
        n = 1;
        req_valid = poke; req_addr = ~a;
        chk(req_ready == 1'b0, "R2", "ready after accept", int'(req_ready), 0);
        while (!resp_valid && n < 40) begin
            if (fill_req_valid) begin
                chk(n == NW + 1, "R5", "fill request cycle", n, NW + 1);
                chk(fill_req_addr == a, "R5", "fill address", int'(fill_req_addr), int'(a));
                chk(!ehit, "R3", "unexpected miss", 1, 0);
                fill_seq++;
                edata = DW'((fill_seq * 97) ^ int'(a));
                fill_rsp_valid = 1'b1; fill_rsp_data = edata;
                m_v[eslot*NS+s] = 1'b1; m_t[eslot*NS+s] = a[7:2]; m_d[eslot*NS+s] = edata;
            end
            @(negedge clk);
            fill_rsp_valid = 1'b0;
            n++;
        end
        req_valid = 1'b0;
        chk(n == elat, "R4", "response latency", n, elat);
        chk(resp_hit == ehit, ehit ? "R7" : "R6", "hit flag", int'(resp_hit), int'(ehit));
        chk(int'(resp_slot) == eslot, ehit ? "R4" : "R6", "slot", int'(resp_slot), eslot);
        chk(resp_data == edata, ehit ? "R4" : "R6", "data", int'(resp_data), int'(edata));
        @(negedge clk);
        chk(resp_valid == 1'b0 && req_ready == 1'b1, "R8", "idle after response",
            int'(resp_valid), 0);
        @(negedge clk);
        chk(resp_valid == 1'b0 && fill_req_valid == 1'b0, "R8", "no extra response",
            int'(resp_valid), 0);
    endtask

    initial begin
        for (int i = 0; i < NB; i++) begin m_v[i] = 1'b0; m_t[i] = '0; m_d[i] = '0; end
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk(req_ready == 1'b1, "R1", "reset ready", int'(req_ready), 1);
        chk(resp_valid == 1'b0, "R1", "reset resp_valid", int'(resp_valid), 0);
        chk(fill_req_valid == 1'b0, "R1", "reset fill_req_valid", int'(fill_req_valid), 0);
        // Fill each set, overflow it, then revisit in reverse (R3, R5, R6, R7).
        for (int s = 0; s < NS; s++) begin
            for (int t = 0; t <= NW; t++) access(AW'(((t * 5 + 1) << 2) | s), 1'b0);
            for (int t = NW; t >= 0; t--) access(AW'(((t * 5 + 1) << 2) | s), t[0]);
        end
        // Same tags in a different set must not alias (R3), final hit pass (R7).
        for (int s = 0; s < NS; s++)
            for (int t = 0; t <= NW; t++) access(AW'(((t * 5 + 1) << 2) | s), 1'b1);
        for (int s = 0; s < NS; s++) access(AW'((63 << 2) | s), 1'b0);
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        failures++;
        $display("FAIL watchdog expired actual=1 expected=0");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule